// File: doc/BRIEF.md
# Block Fill Engine

This engine paints a horizontal run of identical pixels into pixel memory in response to one 32-bit write on its trigger port, provided fill mode is switched on in its mode register. The trigger address selects the word where the run begins. The trigger data word carries two values: the run length minus one, and a byte offset into that word. A host draws a rectangle by issuing one trigger per line. When the rectangle is exactly as wide as the screen line, the host issues a single trigger covering width times height pixels. One trigger fills at most 2048 pixels.

Pixels come from a bank of colour registers and leave at one per cycle on a pixel write port, in ascending address order. In 32 bpp depth each pixel is a 32-bit word. In 8 bpp depth each pixel is a single byte, taken from one of two registers that hold four byte lanes each. A 32-bit fill mask gates each pixel of the run. While a run is in progress the engine raises a busy flag and holds its ready signal low, so a second trigger waits until the current run is done.

Top module: `bfe_block_fill`

## Requirements
- R1: After reset `busy` is 0, `fb_ready` is 1, `pix_we` is 0, the mode register is 0 and the mask register is all ones.
- R2: An accepted trigger whose data bits 10:0 hold N-1 produces exactly N pixel cycles. `busy` is high for exactly those N cycles, starting in the cycle after acceptance.
- R3: Trigger address bits 1:0 are ignored. In 8 bpp the first pixel address is the aligned address plus data bits 17:16, and addresses then step by 1. In 32 bpp bits 17:16 are ignored and addresses step by 4.
- R4: In 32 bpp the pixel at byte address A takes colour register A[4:2]. Register addresses 2 to 9 hold colours 0 to 7.
- R5: In 8 bpp the pixel at byte address A takes byte lane A[1:0] (lane 0 = bits 7:0) of colour register A[2], that is colour 0 or colour 1. The byte appears on `pix_data[7:0]` with bits 31:8 at zero.
- R6: The mask register is at register address 1. Pixel k of a run (k counted from 0) is written only when mask bit k mod 32 is set. Masked pixels still advance the address.
- R7: The mode register is at register address 0: bit 0 enables fill, bit 1 selects 32 bpp. With bit 0 clear, trigger writes are ignored: no pixel writes occur and `busy` stays 0.
- R8: While `busy` is high `fb_ready` is low. A trigger held during a run is accepted once the run ends, and its first pixel follows the last pixel of the earlier run.
- R9: A count field of all ones (2047) fills 2048 pixels.
- R10: Depth and mask are captured when a trigger is accepted. Register writes during a run do not alter that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0 mode, 1 mask, 2..9 colours) |
| reg_wdata | input | 32 | Register write data |
| fb_we | input | 1 | Trigger write strobe |
| fb_addr | input | 24 | Trigger byte address |
| fb_wdata | input | 32 | Trigger data: count-1 in bits 10:0, byte offset in bits 17:16 |
| fb_ready | output | 1 | High when a trigger can be accepted |
| busy | output | 1 | Run in progress (status bit 0) |
| pix_we | output | 1 | Pixel write strobe |
| pix_addr | output | 24 | Pixel byte address |
| pix_data | output | 32 | Pixel value (8 bpp uses bits 7:0) |
| pix_wide | output | 1 | Current pixel is 32 bpp |

## Verification
Any corruption of the remaining-count register shows up as a run that is too short or too long. That error is visible when `busy` falls, N cycles after acceptance. An address or depth register that goes wrong shows on `pix_addr` or `pix_wide` within one cycle, as a step that is neither 1 nor 4 or as a depth that changes in the middle of a run. A wrong colour index or mask index is visible only on the strobe or data of the affected pixel. For that reason the directed runs span more than eight pixels and use irregular mask patterns.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
  typedef enum logic {RUN_IDLE = 1'b0, RUN_ACTIVE = 1'b1} run_state_e;

  typedef struct packed {
    logic wide;
    logic fill;
  } mode_t;

  localparam int unsigned RA_MODE    = 0;
  localparam int unsigned RA_MASK    = 1;
  localparam int unsigned RA_COLOUR0 = 2;
  localparam int unsigned OFFSET_LSB = 16;
  localparam int unsigned OFFSET_W   = 2;
endpackage

// File: rtl/bfe_cmd_decode.sv
module bfe_cmd_decode #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 11
) (
  input  logic [ADDR_W-1:0] fb_addr,
  input  logic [31:0]       fb_wdata,
  input  logic              wide,
  output logic [ADDR_W-1:0] start_addr,
  output logic [CNT_W-1:0]  count_m1
);
  import bfe_pkg::*;

  logic [OFFSET_W-1:0] offset;
  logic                unused_bits;

  assign offset     = wide ? '0 : fb_wdata[OFFSET_LSB +: OFFSET_W];
  assign start_addr = {fb_addr[ADDR_W-1:2], offset};
  assign count_m1   = fb_wdata[CNT_W-1:0];

  assign unused_bits = ^{fb_addr[1:0], fb_wdata[31:OFFSET_LSB+OFFSET_W],
                         fb_wdata[OFFSET_LSB-1:CNT_W]};
endmodule

// File: rtl/bfe_colour_sel.sv
module bfe_colour_sel #(
  parameter int unsigned NUM_COLOUR = 8,
  localparam int unsigned IDX_W     = $clog2(NUM_COLOUR),
  localparam int unsigned LOW_W     = IDX_W + 2
) (
  input  logic [NUM_COLOUR-1:0][31:0] colours,
  input  logic [LOW_W-1:0]            addr_low,
  input  logic                        wide,
  output logic [31:0]                 pix_data
);
  logic [7:0]  lane_byte [4];
  logic [31:0] narrow_word;
  logic [31:0] wide_word;

  assign narrow_word = colours[addr_low[2]];
  assign wide_word   = colours[addr_low[2 +: IDX_W]];

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign lane_byte[l] = narrow_word[8*l +: 8];
  end

  always_comb begin
    if (wide) pix_data = wide_word;
    else      pix_data = {24'h0, lane_byte[addr_low[1:0]]};
  end
endmodule

// File: rtl/bfe_run_ctrl.sv
module bfe_run_ctrl #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  count_m1,
  input  logic              wide_in,
  input  logic [MASK_W-1:0] mask_in,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wide,
  output logic              pix_en
);
  import bfe_pkg::*;

  localparam int unsigned IDX_W = $clog2(MASK_W);

  run_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              wide_q, wide_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              upd_en;

  assign upd_en = start | (state_q == RUN_ACTIVE);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    idx_d   = idx_q;
    wide_d  = wide_q;
    mask_d  = mask_q;
    case (state_q)
      RUN_IDLE: begin
        if (start) begin
          state_d = RUN_ACTIVE;
          addr_d  = start_addr;
          rem_d   = count_m1;
          idx_d   = '0;
          wide_d  = wide_in;
          mask_d  = mask_in;
        end
      end
      RUN_ACTIVE: begin
        if (rem_q == '0) begin
          state_d = RUN_IDLE;
        end else begin
          addr_d = addr_q + (wide_q ? ADDR_W'(4) : ADDR_W'(1));
          rem_d  = rem_q - 1'b1;
          idx_d  = idx_q + 1'b1;
        end
      end
      default: state_d = RUN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      wide_q  <= 1'b0;
      mask_q  <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      idx_q   <= idx_d;
      wide_q  <= wide_d;
      mask_q  <= mask_d;
    end
  end

  assign busy     = (state_q == RUN_ACTIVE);
  assign cur_addr = addr_q;
  assign wide     = wide_q;
  assign pix_en   = busy & mask_q[idx_q];
endmodule

// File: rtl/bfe_block_fill.sv
module bfe_block_fill #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned MAX_RUN    = 2048,
  parameter int unsigned NUM_COLOUR = 8,
  parameter int unsigned REG_AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              fb_we,
  input  logic [ADDR_W-1:0] fb_addr,
  input  logic [31:0]       fb_wdata,
  output logic              fb_ready,
  output logic              busy,
  output logic              pix_we,
  output logic [ADDR_W-1:0] pix_addr,
  output logic [31:0]       pix_data,
  output logic              pix_wide
);
  import bfe_pkg::*;

  localparam int unsigned CNT_W  = $clog2(MAX_RUN);
  localparam int unsigned MASK_W = 32;
  localparam int unsigned LOW_W  = $clog2(NUM_COLOUR) + 2;

  mode_t                       mode_q, mode_d;
  logic [MASK_W-1:0]           mask_q, mask_d;
  logic                        mode_en, mask_en;
  logic [NUM_COLOUR-1:0][31:0] colour_flat;
  logic                        accept;
  logic [ADDR_W-1:0]           start_addr;
  logic [CNT_W-1:0]            count_m1;
  logic                        run_busy;
  logic                        pix_en;

  // Register file
  assign mode_en = reg_we && (reg_addr == REG_AW'(RA_MODE));
  assign mask_en = reg_we && (reg_addr == REG_AW'(RA_MASK));
  assign mode_d  = reg_wdata[1:0];
  assign mask_d  = reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  for (genvar c = 0; c < NUM_COLOUR; c++) begin : g_col
    logic        col_en;
    logic [31:0] col_q;
    assign col_en = reg_we && (reg_addr == REG_AW'(RA_COLOUR0 + c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      col_q <= '0;
      else if (col_en) col_q <= reg_wdata;
    end
    assign colour_flat[c] = col_q;
  end

  // Trigger acceptance
  assign fb_ready = ~run_busy;
  assign accept   = fb_we & fb_ready & mode_q.fill;

  bfe_cmd_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
    .fb_addr    (fb_addr),
    .fb_wdata   (fb_wdata),
    .wide       (mode_q.wide),
    .start_addr (start_addr),
    .count_m1   (count_m1)
  );

  bfe_run_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MASK_W(MASK_W)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_addr (start_addr),
    .count_m1   (count_m1),
    .wide_in    (mode_q.wide),
    .mask_in    (mask_q),
    .busy       (run_busy),
    .cur_addr   (pix_addr),
    .wide       (pix_wide),
    .pix_en     (pix_en)
  );

  bfe_colour_sel #(.NUM_COLOUR(NUM_COLOUR)) u_col (
    .colours  (colour_flat),
    .addr_low (pix_addr[LOW_W-1:0]),
    .wide     (pix_wide),
    .pix_data (pix_data)
  );

  assign busy   = run_busy;
  assign pix_we = pix_en;
endmodule

// File: rtl/bfe_block_fill_chk.sv
module bfe_block_fill_chk #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned MAX_RUN = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fb_we,
  input logic              fb_ready,
  input logic              busy,
  input logic              pix_we,
  input logic [ADDR_W-1:0] pix_addr,
  input logic [31:0]       pix_data,
  input logic              pix_wide
);
  localparam int unsigned CW = $clog2(MAX_RUN) + 1;

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  // R2: pixel writes only during a run
  a_r2_we_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    pix_we |-> busy);

  // R3: addresses ascend by the pixel size
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      (pix_addr == $past(pix_addr) + (pix_wide ? ADDR_W'(4) : ADDR_W'(1))));

  // R5: narrow pixels have zero upper bits
  a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_we && !pix_wide) |-> (pix_data[31:8] == 24'h0));

  // R7: a run only begins from an accepted trigger
  a_r7_start_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fb_we && fb_ready));

  // R9: no run exceeds the maximum length
  a_r9_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < CW'(MAX_RUN)));

  // R10: depth fixed for the whole run
  a_r10_depth_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pix_wide));
endmodule

bind bfe_block_fill bfe_block_fill_chk #(.ADDR_W(ADDR_W), .MAX_RUN(MAX_RUN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fb_we    (fb_we),
  .fb_ready (fb_ready),
  .busy     (busy),
  .pix_we   (pix_we),
  .pix_addr (pix_addr),
  .pix_data (pix_data),
  .pix_wide (pix_wide)
);

// File: tb/sim_bfe_block_fill.sv
module sim_bfe_block_fill;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        fb_we = 1'b0;
  logic [23:0] fb_addr = '0;
  logic [31:0] fb_wdata = '0;
  logic        fb_ready, busy, pix_we, pix_wide;
  logic [23:0] pix_addr;
  logic [31:0] pix_data;

  int checks = 0;
  int errors = 0;
  int rec_n = 0;
  int busy_cyc = 0;
  logic [23:0] rec_addr [64];
  logic [31:0] rec_data [64];
  logic        rec_wide [64];
  logic [23:0] last_addr;
  logic [31:0] col [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  bfe_block_fill u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .fb_we(fb_we), .fb_addr(fb_addr),
    .fb_wdata(fb_wdata), .fb_ready(fb_ready), .busy(busy), .pix_we(pix_we),
    .pix_addr(pix_addr), .pix_data(pix_data), .pix_wide(pix_wide)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cyc = busy_cyc + 1;
      if (pix_we) begin
        if (rec_n < 64) begin
          rec_addr[rec_n] = pix_addr;
          rec_data[rec_n] = pix_data;
          rec_wide[rec_n] = pix_wide;
        end
        last_addr = pix_addr;
        rec_n = rec_n + 1;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic trigger(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    fb_we = 1'b1; fb_addr = a; fb_wdata = d;
    while (!fb_ready) @(negedge clk);
    @(negedge clk);
    fb_we = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_rec();
    rec_n = 0;
    busy_cyc = 0;
  endtask

  function automatic logic [31:0] exp8(input logic [23:0] a);
    logic [31:0] w;
    w = col[a[2]];
    return {24'h0, w[8*a[1:0] +: 8]};
  endfunction

  task automatic load_colours();
    for (int i = 0; i < 8; i++) begin
      col[i] = 32'hC0DE_0000 + 32'(i) * 32'h0000_1111;
      wr_reg(4'(2 + i), col[i]);
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", {31'h0, busy}, 32'h0);
    chk("R1", "fb_ready", {31'h0, fb_ready}, 32'h1);
    chk("R1", "pix_we", {31'h0, pix_we}, 32'h0);
  endtask

  task automatic t_run32();
    logic [23:0] a;
    wr_reg(4'd0, 32'h3);
    clear_rec();
    trigger(24'h000102, 32'h0002_0009);
    wait_idle();
    chk("R2", "pixel count", 32'(rec_n), 32'd10);
    chk("R2", "busy cycles", 32'(busy_cyc), 32'd10);
    for (int k = 0; k < 10; k++) begin
      a = 24'h000100 + 24'(4 * k);
      chk("R3", "wide address", {8'h0, rec_addr[k]}, {8'h0, a});
      chk("R4", "wide colour", rec_data[k], col[a[4:2]]);
    end
  endtask

  task automatic t_run8();
    logic [23:0] a;
    wr_reg(4'd0, 32'h1);
    clear_rec();
    trigger(24'h000201, 32'h0003_0005);
    wait_idle();
    chk("R2", "narrow pixel count", 32'(rec_n), 32'd6);
    for (int k = 0; k < 6; k++) begin
      a = 24'h000203 + 24'(k);
      chk("R3", "narrow address", {8'h0, rec_addr[k]}, {8'h0, a});
      chk("R5", "narrow colour", rec_data[k], exp8(a));
      chk("R5", "narrow flag", {31'h0, rec_wide[k]}, 32'h0);
    end
  endtask

  task automatic t_mask();
    wr_reg(4'd0, 32'h3);
    wr_reg(4'd1, 32'hFFFF_FFA5);
    clear_rec();
    trigger(24'h000300, 32'h0000_0007);
    wait_idle();
    chk("R6", "masked count", 32'(rec_n), 32'd4);
    chk("R6", "masked busy", 32'(busy_cyc), 32'd8);
    chk("R6", "pixel 0", {8'h0, rec_addr[0]}, 32'h300);
    chk("R6", "pixel 2", {8'h0, rec_addr[1]}, 32'h308);
    chk("R6", "pixel 5", {8'h0, rec_addr[2]}, 32'h314);
    chk("R6", "pixel 7", {8'h0, rec_addr[3]}, 32'h31C);
    wr_reg(4'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_ignored();
    wr_reg(4'd0, 32'h2);
    clear_rec();
    trigger(24'h000080, 32'h0000_0004);
    repeat (10) @(negedge clk);
    chk("R7", "no pixels when fill off", 32'(rec_n), 32'd0);
    chk("R7", "no busy when fill off", 32'(busy_cyc), 32'd0);
  endtask

  task automatic t_stall();
    wr_reg(4'd0, 32'h3);
    clear_rec();
    trigger(24'h000500, 32'h0000_0013);
    chk("R8", "ready low while busy", {31'h0, fb_ready}, 32'h0);
    trigger(24'h000700, 32'h0000_0002);
    wait_idle();
    chk("R8", "total pixels", 32'(rec_n), 32'd23);
    chk("R8", "last of first run", {8'h0, rec_addr[19]}, 32'h54C);
    chk("R8", "first of held run", {8'h0, rec_addr[20]}, 32'h700);
  endtask

  task automatic t_latch();
    wr_reg(4'd0, 32'h3);
    clear_rec();
    trigger(24'h000400, 32'h0000_000F);
    wr_reg(4'd0, 32'h1);
    wr_reg(4'd1, 32'h0);
    wait_idle();
    chk("R10", "count after mid-run writes", 32'(rec_n), 32'd16);
    chk("R10", "depth kept", {31'h0, rec_wide[15]}, 32'h1);
    chk("R10", "last address", {8'h0, rec_addr[15]}, 32'h43C);
    wr_reg(4'd1, 32'hFFFF_FFFF);
    wr_reg(4'd0, 32'h3);
  endtask

  task automatic t_max();
    wr_reg(4'd0, 32'h3);
    clear_rec();
    trigger(24'h000000, 32'h0000_07FF);
    wait_idle();
    chk("R9", "max run pixels", 32'(rec_n), 32'd2048);
    chk("R9", "max run busy", 32'(busy_cyc), 32'd2048);
    chk("R9", "max run last address", {8'h0, last_addr}, 32'h1FFC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    load_colours();
    t_run32();
    t_run8();
    t_mask();
    t_ignored();
    t_stall();
    t_latch();
    t_max();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule